// File: doc/BRIEF.md
# Call, Return and Trap Stack Sequencer

This block performs the memory and stack-pointer side of control transfers that go through memory. These are subroutine calls and returns, software traps (plain, or with a new interrupt level), return from a trap, entry into a debug handler, and return from that handler. It owns the stack pointer. It reaches memory through one single-word request/ready port. After a multi-cycle sequence it hands back the new program counter, and where the operation calls for it, a new status byte and a new r0.

The surrounding core starts an operation with a one-cycle `start` and supplies everything the operation needs: the operation code, the delay bit, the current pc, status byte and r0, the call target that the branch unit has already computed, the trap-table base, the debug save-area base and the immediate fields. `busy` stays high while the sequence runs. In the cycle after `busy` falls, `done` pulses once, together with write strobes that say which of the new values the core must take.

Saved words place the 8-bit status in bits 31:24 and the 24-bit pc in bits 23:0. In the status byte, bit 4 is the interrupt-enable flag and bits 7:5 are the interrupt level.

Top module: `stack_seq`

## Requirements
- R1: After reset, `busy`, `done`, `mem_req` and all three write strobes are 0, and `sp` equals the parameter SP_RESET.
- R2: Operation code 0 (call) writes {8'h00, pc+2} at sp-4, or {8'h00, pc+4} when the delay bit is 1. It then leaves sp at sp-4, and `new_pc` is the supplied call target.
- R3: Operation code 1 (return) reads the word at sp. `new_pc` is bits 23:0 of that word, and sp then increases by 4.
- R4: Operation code 2 (trap) first writes {status, pc+2} at sp-4. It then reads the vector at trap_base + imm5×4. `new_pc` is bits 23:0 of the vector, the new status is the old status with bit 4 cleared, and sp ends at sp-4.
- R5: Operation code 3 (trap with level) behaves as R4 and also puts imm3 into status bits 7:5.
- R6: Operation code 4 (trap return) reads the word at sp. The new status is bits 31:24 of that word, `new_pc` is bits 23:0, and sp increases by 4.
- R7: Operation code 5 (debug entry) writes {status, pc+2} at dbg_base and then {8'h00, r0} at dbg_base+4. `new_pc` is DBG_VECTOR (default 0xFFFC00), sp is unchanged and no new status is issued.
- R8: Operation code 6 (debug return) first reads dbg_base+4 and gives bits 23:0 as the new r0. It then reads dbg_base, which supplies the new status (31:24) and pc (23:0). sp is unchanged.
- R9: With memory that is ready at once, `busy` is high for 4 cycles for call and return (3 with the delay bit), 3 cycles for trap return (2 with the delay bit), and 3 cycles for trap, trap with level, debug entry and debug return whatever the delay bit.
- R10: A request keeps `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady until `mem_ready` is seen, and each cycle spent waiting lengthens `busy` by exactly one. `mem_req` is never high while `busy` is low.
- R11: `done` is a one-cycle pulse in the cycle after `busy` falls. `pc_wr` is high with every `done`. `psr_wr` is high only for codes 2, 3, 4 and 6, and `r0_wr` only for code 6. All strobes are low when `done` is low.
- R12: `start` has no effect while `busy` is high, and `start` with operation code 7 starts nothing.
- R13: The stack pointer moves only in steps of 4 and wraps modulo 2^24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| op | input | 3 | Operation code, see R2 to R8 and R12 |
| dly | input | 1 | Delay bit of the instruction |
| cur_pc | input | 24 | Address of the current instruction |
| cur_psr | input | 8 | Current status byte |
| cur_r0 | input | 24 | Current r0 value |
| call_tgt | input | 24 | Call target from the branch unit |
| trap_base | input | 24 | Trap vector table base |
| dbg_base | input | 24 | Debug save area base |
| imm5 | input | 5 | Trap vector number |
| imm3 | input | 3 | Interrupt level for trap with level |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 24 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes this cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Results valid, one cycle |
| sp | output | 24 | Stack pointer |
| new_pc | output | 24 | Resulting program counter |
| new_psr | output | 8 | Resulting status byte |
| new_r0 | output | 24 | Resulting r0 |
| pc_wr | output | 1 | Take new_pc |
| psr_wr | output | 1 | Take new_psr |
| r0_wr | output | 1 | Take new_r0 |

## Verification
The bench builds the block with SP_RESET set to 0x000008 and keeps the default debug vector. With that reset value, two calls bring the pointer to zero and the next trap push wraps it to 0xFFFFFC. The returns that follow then cross zero upward, so both directions of the 24-bit wrap are exercised on real memory traffic. A memory responder in the bench is programmed per operation with zero, one or two wait cycles, which covers both the bare cycle counts and their stretching under the handshake.

// File: rtl/ss_pkg.sv
// Shared constants and types for the stack sequencer.
// Assumes a 24-bit byte address space and 32-bit memory words that hold
// an 8-bit status byte above a 24-bit pc.
package ss_pkg;
    localparam int AW     = 24;            // address and pc width
    localparam int PW     = 8;             // status byte width
    localparam int DW     = PW + AW;       // memory word width
    localparam int PADW   = 2;             // width of the pad counter
    localparam int IE_BIT = 4;             // interrupt enable position
    localparam int IL_LSB = 5;             // interrupt level low bit
    localparam int IL_W   = 3;             // interrupt level width
    localparam int STEP   = 4;             // stack step in bytes

    typedef enum logic [2:0] {
        OP_CALL = 3'd0,
        OP_RET  = 3'd1,
        OP_TRAP = 3'd2,
        OP_TRPL = 3'd3,
        OP_TRET = 3'd4,
        OP_DBGE = 3'd5,
        OP_DBGR = 3'd6,
        OP_NONE = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MEM  = 2'd1,
        ST_PAD  = 2'd2
    } st_e;

    typedef struct packed {
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } acc_t;
endpackage

// File: rtl/ss_plan.sv
// Access planner: for the latched operation and the current phase it
// gives the memory access, whether a second phase follows, how many
// pad cycles close the sequence and how the stack pointer moves.
// Assumes all inputs are stable for the whole operation (latched copies).
module ss_plan
    import ss_pkg::*;
(
    input  op_e              op,
    input  logic             dly,
    input  logic             phase,
    input  logic [AW-1:0]    sp,
    input  logic [AW-1:0]    pc,
    input  logic [PW-1:0]    psr,
    input  logic [AW-1:0]    r0,
    input  logic [AW-1:0]    trap_base,
    input  logic [AW-1:0]    dbg_base,
    input  logic [4:0]       imm5,
    output acc_t             acc,
    output logic             two_phase,
    output logic [PADW-1:0]  pad,
    output logic             sp_dec,
    output logic             sp_inc
);
    localparam logic [AW-1:0] STEP_A = AW'(STEP);

    logic [AW-1:0] ret2, ret4, push_a, vec_a;

    // Candidate addresses and return values shared by several operations.
    always_comb begin
        ret2   = pc + AW'(2);
        ret4   = pc + AW'(4);
        push_a = sp - STEP_A;
        vec_a  = trap_base + AW'({imm5, 2'b00});
    end

    // Per-operation access plan.
    always_comb begin
        acc       = '0;
        two_phase = 1'b0;
        pad       = PADW'(1);
        sp_dec    = 1'b0;
        sp_inc    = 1'b0;
        unique case (op)
            OP_CALL: begin
                acc    = '{we: 1'b1, addr: push_a,
                           wdata: {{PW{1'b0}}, (dly ? ret4 : ret2)}};
                pad    = dly ? PADW'(2) : PADW'(3);
                sp_dec = 1'b1;
            end
            OP_RET: begin
                acc    = '{we: 1'b0, addr: sp, wdata: '0};
                pad    = dly ? PADW'(2) : PADW'(3);
                sp_inc = 1'b1;
            end
            OP_TRAP, OP_TRPL: begin
                two_phase = 1'b1;
                sp_dec    = 1'b1;
                if (!phase) acc = '{we: 1'b1, addr: push_a, wdata: {psr, ret2}};
                else        acc = '{we: 1'b0, addr: vec_a, wdata: '0};
            end
            OP_TRET: begin
                acc    = '{we: 1'b0, addr: sp, wdata: '0};
                pad    = dly ? PADW'(1) : PADW'(2);
                sp_inc = 1'b1;
            end
            OP_DBGE: begin
                two_phase = 1'b1;
                if (!phase) acc = '{we: 1'b1, addr: dbg_base, wdata: {psr, ret2}};
                else        acc = '{we: 1'b1, addr: dbg_base + STEP_A,
                                    wdata: {{PW{1'b0}}, r0}};
            end
            OP_DBGR: begin
                two_phase = 1'b1;
                if (!phase) acc = '{we: 1'b0, addr: dbg_base + STEP_A, wdata: '0};
                else        acc = '{we: 1'b0, addr: dbg_base, wdata: '0};
            end
            default: begin
                acc = '0;
            end
        endcase
    end
endmodule

// File: rtl/ss_result.sv
// Result former: builds the new pc, status and r0 and their strobes from
// the latched operands and the words read during the sequence.
// Assumes rd0/rd1 hold the data of the first and second read phase.
module ss_result
    import ss_pkg::*;
#(
    parameter logic [AW-1:0] DBG_VECTOR = 24'hFFFC00
)(
    input  op_e              op,
    input  logic [PW-1:0]    psr,
    input  logic [AW-1:0]    tgt,
    input  logic [IL_W-1:0]  imm3,
    input  logic [DW-1:0]    rd0,
    input  logic [DW-1:0]    rd1,
    output logic [AW-1:0]    res_pc,
    output logic [PW-1:0]    res_psr,
    output logic [AW-1:0]    res_r0,
    output logic             res_psr_we,
    output logic             res_r0_we
);
    // Select results by operation.
    always_comb begin
        res_pc     = tgt;
        res_psr    = psr;
        res_r0     = '0;
        res_psr_we = 1'b0;
        res_r0_we  = 1'b0;
        unique case (op)
            OP_CALL: res_pc = tgt;
            OP_RET:  res_pc = rd0[AW-1:0];
            OP_TRAP, OP_TRPL: begin
                res_pc          = rd1[AW-1:0];
                res_psr         = psr;
                res_psr[IE_BIT] = 1'b0;
                if (op == OP_TRPL) res_psr[IL_LSB +: IL_W] = imm3;
                res_psr_we      = 1'b1;
            end
            OP_TRET: begin
                res_pc     = rd0[AW-1:0];
                res_psr    = rd0[DW-1:AW];
                res_psr_we = 1'b1;
            end
            OP_DBGE: res_pc = DBG_VECTOR;
            OP_DBGR: begin
                res_r0     = rd0[AW-1:0];
                res_pc     = rd1[AW-1:0];
                res_psr    = rd1[DW-1:AW];
                res_psr_we = 1'b1;
                res_r0_we  = 1'b1;
            end
            default: res_pc = tgt;
        endcase
    end
endmodule

// File: rtl/ss_sp_reg.sv
// Stack pointer register: steps down or up by one word on request and
// wraps modulo the address space. Assumes dec and inc are never both set.
module ss_sp_reg
    import ss_pkg::*;
#(
    parameter logic [AW-1:0] SP_RESET = '0
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dec,
    input  logic          inc,
    output logic [AW-1:0] sp
);
    localparam logic [AW-1:0] STEP_A = AW'(STEP);

    // Hold or step the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n)   sp <= SP_RESET;
        else if (dec) sp <= sp - STEP_A;
        else if (inc) sp <= sp + STEP_A;
    end

    // R13
    sp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sp) |-> (sp == $past(sp) - STEP_A) || (sp == $past(sp) + STEP_A));
endmodule

// File: rtl/stack_seq.sv
// Call, return and trap stack sequencer (top). Latches one operation on
// start, runs up to two memory phases through a request/ready port, pads
// to the operation's cycle budget and then pulses done with results.
// Assumes the core keeps using the old pc/psr/r0 until done.
module stack_seq
    import ss_pkg::*;
#(
    parameter logic [23:0] SP_RESET   = 24'h000000,
    parameter logic [23:0] DBG_VECTOR = 24'hFFFC00
)(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [2:0]  op,
    input  logic        dly,
    input  logic [23:0] cur_pc,
    input  logic [7:0]  cur_psr,
    input  logic [23:0] cur_r0,
    input  logic [23:0] call_tgt,
    input  logic [23:0] trap_base,
    input  logic [23:0] dbg_base,
    input  logic [4:0]  imm5,
    input  logic [2:0]  imm3,
    output logic        mem_req,
    output logic        mem_we,
    output logic [23:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ready,
    output logic        busy,
    output logic        done,
    output logic [23:0] sp,
    output logic [23:0] new_pc,
    output logic [7:0]  new_psr,
    output logic [23:0] new_r0,
    output logic        pc_wr,
    output logic        psr_wr,
    output logic        r0_wr
);
    st_e             st;
    op_e             op_q;
    logic            dly_q, phase;
    logic [AW-1:0]   pc_q, r0_q, tgt_q, tb_q, db_q;
    logic [PW-1:0]   psr_q;
    logic [4:0]      imm5_q;
    logic [IL_W-1:0] imm3_q;
    logic [DW-1:0]   rd0_q, rd1_q;
    logic [PADW-1:0] pad_cnt;

    acc_t            acc;
    logic            two_phase, p_dec, p_inc, fire, last_phase;
    logic [PADW-1:0] pad;
    logic [AW-1:0]   res_pc, res_r0;
    logic [PW-1:0]   res_psr;
    logic            res_psr_we, res_r0_we;

    ss_plan u_plan (
        .op(op_q), .dly(dly_q), .phase(phase), .sp(sp), .pc(pc_q),
        .psr(psr_q), .r0(r0_q), .trap_base(tb_q), .dbg_base(db_q),
        .imm5(imm5_q), .acc(acc), .two_phase(two_phase), .pad(pad),
        .sp_dec(p_dec), .sp_inc(p_inc)
    );

    ss_result #(.DBG_VECTOR(DBG_VECTOR)) u_res (
        .op(op_q), .psr(psr_q), .tgt(tgt_q), .imm3(imm3_q),
        .rd0(rd0_q), .rd1(rd1_q), .res_pc(res_pc), .res_psr(res_psr),
        .res_r0(res_r0), .res_psr_we(res_psr_we), .res_r0_we(res_r0_we)
    );

    // Access completion and the final memory phase of the operation.
    always_comb begin
        fire       = (st == ST_MEM) && mem_ready;
        last_phase = !two_phase || phase;
    end

    // The pointer moves once, when the first phase completes.
    ss_sp_reg #(.SP_RESET(SP_RESET)) u_sp (
        .clk(clk), .rst_n(rst_n),
        .dec(fire && !phase && p_dec),
        .inc(fire && !phase && p_inc),
        .sp(sp)
    );

    // Memory port drive from the current plan.
    always_comb begin
        mem_req   = (st == ST_MEM);
        mem_we    = mem_req && acc.we;
        mem_addr  = acc.addr;
        mem_wdata = acc.wdata;
        busy      = (st != ST_IDLE);
    end

    // Sequence state, operand latch, read capture and pad count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            op_q    <= OP_NONE;
            dly_q   <= 1'b0;
            phase   <= 1'b0;
            pc_q    <= '0;
            psr_q   <= '0;
            r0_q    <= '0;
            tgt_q   <= '0;
            tb_q    <= '0;
            db_q    <= '0;
            imm5_q  <= '0;
            imm3_q  <= '0;
            rd0_q   <= '0;
            rd1_q   <= '0;
            pad_cnt <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (start && (op_e'(op) != OP_NONE)) begin
                        st     <= ST_MEM;
                        op_q   <= op_e'(op);
                        dly_q  <= dly;
                        phase  <= 1'b0;
                        pc_q   <= cur_pc;
                        psr_q  <= cur_psr;
                        r0_q   <= cur_r0;
                        tgt_q  <= call_tgt;
                        tb_q   <= trap_base;
                        db_q   <= dbg_base;
                        imm5_q <= imm5;
                        imm3_q <= imm3;
                    end
                end
                ST_MEM: begin
                    if (mem_ready) begin
                        if (!phase) rd0_q <= mem_rdata;
                        else        rd1_q <= mem_rdata;
                        if (last_phase) begin
                            st      <= ST_PAD;
                            pad_cnt <= pad;
                        end else begin
                            phase <= 1'b1;
                        end
                    end
                end
                ST_PAD: begin
                    if (pad_cnt == PADW'(1)) st <= ST_IDLE;
                    pad_cnt <= pad_cnt - PADW'(1);
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Result registers and the one-cycle completion strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done    <= 1'b0;
            pc_wr   <= 1'b0;
            psr_wr  <= 1'b0;
            r0_wr   <= 1'b0;
            new_pc  <= '0;
            new_psr <= '0;
            new_r0  <= '0;
        end else begin
            done   <= 1'b0;
            pc_wr  <= 1'b0;
            psr_wr <= 1'b0;
            r0_wr  <= 1'b0;
            if (st == ST_PAD && pad_cnt == PADW'(1)) begin
                done    <= 1'b1;
                pc_wr   <= 1'b1;
                psr_wr  <= res_psr_we;
                r0_wr   <= res_r0_we;
                new_pc  <= res_pc;
                new_psr <= res_psr;
                new_r0  <= res_r0;
            end
        end
    end

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> mem_req && $stable(mem_addr)
                                     && $stable(mem_we) && $stable(mem_wdata));
    // R10
    req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);
    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R11
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !busy && $past(busy));
    // R12
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
endmodule

// File: tb/stack_seq_test.sv
module stack_seq_test;
    localparam logic [23:0] SPR = 24'h000008;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = 3'd7;
    logic        dly = 1'b0;
    logic [23:0] cur_pc = '0, cur_r0 = '0, call_tgt = '0;
    logic [7:0]  cur_psr = '0;
    logic [23:0] trap_base = 24'h000200, dbg_base = 24'h000800;
    logic [4:0]  imm5 = '0;
    logic [2:0]  imm3 = '0;
    logic        mem_req, mem_we, mem_ready = 1'b0;
    logic [23:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata = '0;
    logic        busy, done, pc_wr, psr_wr, r0_wr;
    logic [23:0] sp, new_pc, new_r0;
    logic [7:0]  new_psr;

    stack_seq #(.SP_RESET(SPR)) uut (.*);

    always #10 clk = ~clk;

    int total = 0, bad = 0, cyc = 0;
    logic [31:0] mem [logic [23:0]];
    bit          qwe [$];
    logic [23:0] qaddr [$];
    logic [31:0] qdata [$];
    logic [23:0] m_sp = SPR, e_pc, e_r0;
    logic [7:0]  e_psr;
    bit          e_psrw, e_r0w, pending = 0, seen_done = 0, prev_busy = 0;
    int          wcfg = 0, wleft = 0, waits = 0, bcnt = 0, e_bud = 0;
    string       cur_tag = "R2";

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic [31:0] rd(input logic [23:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // One clock: sample at the falling edge, compare, drive the responder.
    task automatic tick();
        @(negedge clk);
        cyc++;
        if (busy) bcnt++;
        check(done || !(pc_wr || psr_wr || r0_wr), "R11", {29'd0, pc_wr, psr_wr, r0_wr}, 0);
        if (busy && !pending) check(0, "R12", 1, 0);
        if (mem_req) begin
            if (qwe.size() == 0) begin
                check(0, "R12", {8'h0, mem_addr}, 0);
                mem_ready = 1'b1;
            end else if (wleft > 0) begin
                mem_ready = 1'b0;
                wleft--;
                waits++;
            end else begin
                mem_ready = 1'b1;
                wleft = wcfg;
                check(mem_we == qwe[0], cur_tag, {31'd0, mem_we}, {31'd0, qwe[0]});
                check(mem_addr == qaddr[0], cur_tag, {8'h0, mem_addr}, {8'h0, qaddr[0]});
                if (qwe[0]) begin
                    check(mem_wdata == qdata[0], cur_tag, mem_wdata, qdata[0]);
                    mem[mem_addr] = mem_wdata;
                end else begin
                    mem_rdata = rd(mem_addr);
                end
                void'(qwe.pop_front()); void'(qaddr.pop_front()); void'(qdata.pop_front());
            end
        end else begin
            mem_ready = 1'b0;
            wleft = wcfg;
        end
        if (done) begin
            check(pending, "R11", {31'd0, done}, 0);
            check(!busy && prev_busy, "R11", {30'd0, busy, prev_busy}, 32'h1);
            check(bcnt == e_bud + waits, (waits > 0) ? "R10" : "R9", bcnt, e_bud + waits);
            check(new_pc == e_pc, cur_tag, {8'h0, new_pc}, {8'h0, e_pc});
            check(pc_wr && psr_wr == e_psrw && r0_wr == e_r0w, "R11",
                  {29'd0, pc_wr, psr_wr, r0_wr}, {29'd0, 1'b1, e_psrw, e_r0w});
            if (e_psrw) check(new_psr == e_psr, cur_tag, {24'h0, new_psr}, {24'h0, e_psr});
            if (e_r0w)  check(new_r0 == e_r0, "R8", {8'h0, new_r0}, {8'h0, e_r0});
            check(sp == m_sp, (m_sp < 24'h10 || m_sp > 24'hFFFFF0) ? "R13" : cur_tag,
                  {8'h0, sp}, {8'h0, m_sp});
            check(qwe.size() == 0, "R10", qwe.size(), 0);
            pending = 0;
            seen_done = 1;
        end
        prev_busy = busy;
    endtask

    task automatic push_acc(input bit we, input logic [23:0] a, input logic [31:0] d);
        qwe.push_back(we); qaddr.push_back(a); qdata.push_back(d);
    endtask

    // Reference model of one operation, then run it and wait for done.
    task automatic run_op(input logic [2:0] o, input bit d, input int w,
                          input logic [23:0] pc, input logic [7:0] psr,
                          input logic [23:0] r0, input logic [23:0] tgt,
                          input logic [4:0] i5, input logic [2:0] i3,
                          input bit poke, input string tag);
        logic [31:0] t;
        logic [23:0] va;
        cur_tag = tag; e_psrw = 0; e_r0w = 0; e_psr = psr; e_r0 = 0;
        case (o)
            3'd0: begin
                push_acc(1, m_sp - 24'd4, {8'h0, pc + (d ? 24'd4 : 24'd2)});
                m_sp = m_sp - 24'd4; e_pc = tgt; e_bud = d ? 3 : 4;
            end
            3'd1: begin
                push_acc(0, m_sp, 0); t = rd(m_sp); e_pc = t[23:0];
                m_sp = m_sp + 24'd4; e_bud = d ? 3 : 4;
            end
            3'd2, 3'd3: begin
                push_acc(1, m_sp - 24'd4, {psr, pc + 24'd2});
                va = trap_base + {17'd0, i5, 2'b00};
                push_acc(0, va, 0); t = rd(va); e_pc = t[23:0];
                e_psr = psr & 8'hEF;
                if (o == 3'd3) e_psr[7:5] = i3;
                e_psrw = 1; m_sp = m_sp - 24'd4; e_bud = 3;
            end
            3'd4: begin
                push_acc(0, m_sp, 0); t = rd(m_sp);
                e_pc = t[23:0]; e_psr = t[31:24]; e_psrw = 1;
                m_sp = m_sp + 24'd4; e_bud = d ? 2 : 3;
            end
            3'd5: begin
                push_acc(1, dbg_base, {psr, pc + 24'd2});
                push_acc(1, dbg_base + 24'd4, {8'h0, r0});
                e_pc = 24'hFFFC00; e_bud = 3;
            end
            default: begin
                push_acc(0, dbg_base + 24'd4, 0); t = rd(dbg_base + 24'd4); e_r0 = t[23:0];
                push_acc(0, dbg_base, 0); t = rd(dbg_base);
                e_pc = t[23:0]; e_psr = t[31:24]; e_psrw = 1; e_r0w = 1; e_bud = 3;
            end
        endcase
        wcfg = w; wleft = w; waits = 0; bcnt = 0; seen_done = 0;
        op = o; dly = d; cur_pc = pc; cur_psr = psr; cur_r0 = r0; call_tgt = tgt;
        imm5 = i5; imm3 = i3; start = 1'b1; pending = 1;
        tick();
        start = 1'b0;
        for (int k = 0; k < 200 && !seen_done; k++) begin
            if (poke && k == 1) begin
                start = 1'b1; op = 3'd1; cur_pc = 24'h555555; call_tgt = 24'h777777;
            end else begin
                start = 1'b0;
            end
            tick();
        end
        start = 1'b0;
        if (!seen_done) check(0, "watchdog", 0, 1);
        tick();
    endtask

    initial begin
        mem[24'h00020C] = 32'h00ABCDEF;
        mem[24'h00027C] = 32'h00345678;
        repeat (3) tick();
        // R1: reset state
        check(!busy && !done && !mem_req, "R1", {29'd0, busy, done, mem_req}, 0);
        check(!pc_wr && !psr_wr && !r0_wr, "R1", {29'd0, pc_wr, psr_wr, r0_wr}, 0);
        check(sp == SPR, "R1", {8'h0, sp}, {8'h0, SPR});
        rst_n = 1'b1;
        tick();
        // R2 calls, plain then delayed with waits
        run_op(3'd0, 0, 0, 24'h001000, 8'h00, 0, 24'h004000, 0, 0, 0, "R2");
        run_op(3'd0, 1, 2, 24'h004010, 8'h00, 0, 24'h005000, 0, 0, 0, "R2");
        // R4 trap: push wraps below zero (R13)
        run_op(3'd2, 0, 0, 24'h005020, 8'hFF, 0, 0, 5'd3, 0, 0, "R4");
        // R5 trap with level, one wait
        run_op(3'd3, 1, 1, 24'h0A0000, 8'h13, 0, 0, 5'd31, 3'd2, 0, "R5");
        // R6 trap returns, plain then delayed
        run_op(3'd4, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6");
        run_op(3'd4, 1, 1, 0, 0, 0, 0, 0, 0, 0, "R6");
        // R3 returns; the second is poked with start while busy (R12)
        run_op(3'd1, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R3");
        run_op(3'd1, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R12");
        // R7 / R8 debug entry and return, both delay settings
        run_op(3'd5, 0, 1, 24'h00F000, 8'h5A, 24'h123456, 0, 0, 0, 0, "R7");
        run_op(3'd6, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
        run_op(3'd5, 1, 0, 24'h00F100, 8'hA5, 24'h00BEEF, 0, 0, 0, 0, "R7");
        run_op(3'd6, 1, 2, 0, 0, 0, 0, 0, 0, 0, "R8");
        // R12: code 7 starts nothing
        op = 3'd7; start = 1'b1;
        tick();
        start = 1'b0;
        repeat (4) tick();
        check(!busy && !done, "R12", {30'd0, busy, done}, 0);
        check(sp == m_sp, "R12", {8'h0, sp}, {8'h0, m_sp});
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule